// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Threshold Flags

This block is a first-in first-out buffer whose write side and read side run on two unrelated clocks. Words are 9 bits wide and the depth is a power of two (256 by default). A producer presents a word with a write strobe on the write clock. A consumer pulls words with a read strobe on the read clock and sees each word on a registered output one read-clock edge later.

Four active-low status outputs describe the fill level: full and almost-full in the write clock domain, and empty and almost-empty in the read clock domain. The almost thresholds come from two run-time offsets, m on the full side and n on the empty side. Both offsets reset to 7 and are loaded through a small parallel port in the write clock domain. Pointers cross between the domains in Gray code through two-flop synchronizers. A flag therefore asserts on the same edge as the local operation that causes it, and releases a few cycles after the opposite side has moved.

Top module: `dual_clock_flag_fifo`

## Requirements
- R1: Words leave in the order they were accepted, with all 9 bits intact. A word taken by an accepted read appears on rdData after the next rising edge of rdClk.
- R2: fullN goes low on the rising wrClk edge that accepts the DEPTH-th stored word, and it is low whenever the buffer holds DEPTH words.
- R3: A write presented while fullN is low is ignored. The stored contents and the word count do not change.
- R4: emptyN goes low on the rising rdClk edge that takes the last stored word, and it is low whenever the buffer holds no words. A read presented while emptyN is low is ignored, and rdData holds its previous value.
- R5: almostFullN, updated on wrClk, is low when the count is DEPTH-m or more and high when the count is DEPTH-m-1 or less.
- R6: almostEmptyN, updated on rdClk, is low when the count is n or less and high when the count is n+1 or more.
- R7: While rstN is low (asynchronous, active low), both pointers clear and both offsets return to 7. The outputs are emptyN=0, almostEmptyN=0, almostFullN=1, fullN=1 and rdData=0.
- R8: A wrClk edge with cfgLoad high stores cfgValue into n when cfgSel=0 and into m when cfgSel=1.
- R9: Each pointer changes by at most one bit per edge in its crossing (Gray) form. Once the opposite side has been idle for 8 cycles of the local clock, every flag matches its threshold definition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wrClk | input | 1 | Write-side clock |
| rdClk | input | 1 | Read-side clock |
| rstN | input | 1 | Asynchronous reset for both domains, active low |
| wrEn | input | 1 | Write request |
| wrData | input | DATA_W (9) | Word to store |
| rdEn | input | 1 | Read request |
| rdData | output | DATA_W (9) | Registered word from the most recent accepted read |
| cfgLoad | input | 1 | Offset load strobe (write domain) |
| cfgSel | input | 1 | 0 selects empty-side offset n, 1 selects full-side offset m |
| cfgValue | input | ADDR_W (8) | Offset value to load |
| fullN | output | 1 | Low when full |
| almostFullN | output | 1 | Low when count is at least DEPTH-m |
| almostEmptyN | output | 1 | Low when count is at most n |
| emptyN | output | 1 | Low when empty |

## Verification
The assertions assume that rstN is applied to both domains together. They also assume that the offsets change only while the buffer is empty and both sides are idle, because the empty-side offset is read in the read domain without a synchronizer. The stimulus keeps to this by draining the buffer and waiting for several cycles of each clock before every offset load. It also steps the fill level one operation at a time and lets the opposite domain settle before comparing any flag against its threshold range.

// File: rtl/fifo_flag_pkg.sv
package fifo_flag_pkg;
  typedef struct packed {
    logic push;
    logic pop;
  } fifo_strobe_t;

  localparam bit CFG_SEL_EMPTY = 1'b0;
  localparam bit CFG_SEL_FULL  = 1'b1;
endpackage

// File: rtl/fifo_flag_ctrl.sv
module fifo_flag_ctrl
  import fifo_flag_pkg::*;
#(
  parameter int DEPTH   = 256,
  parameter int ADDR_W  = $clog2(DEPTH),
  parameter int RST_OFS = 7
) (
  input  logic              wrClk,
  input  logic              rdClk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic              cfgLoad,
  input  logic              cfgSel,
  input  logic [ADDR_W-1:0] cfgValue,
  output fifo_strobe_t      strobe,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [ADDR_W-1:0] rdAddr,
  output logic              fullN,
  output logic              almostFullN,
  output logic              almostEmptyN,
  output logic              emptyN
);
  localparam int PTR_W = ADDR_W + 1;
  localparam logic [PTR_W-1:0] FULL_CNT = PTR_W'(DEPTH);

  function automatic logic [PTR_W-1:0] grayToBin(input logic [PTR_W-1:0] g);
    logic [PTR_W-1:0] b;
    b[PTR_W-1] = g[PTR_W-1];
    for (int i = PTR_W - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  // offsets, write domain
  logic [ADDR_W-1:0] fullOfs, emptyOfs;
  always_ff @(posedge wrClk or negedge rstN) begin
    if (!rstN) begin
      fullOfs  <= ADDR_W'(RST_OFS);
      emptyOfs <= ADDR_W'(RST_OFS);
    end else if (cfgLoad) begin
      if (cfgSel == CFG_SEL_FULL) fullOfs <= cfgValue;
      else                        emptyOfs <= cfgValue;
    end
  end

  // write side
  logic [PTR_W-1:0] wBin, wGray, wBinNext, rSyncA, rSyncB, rBinW, wCountNext, wCountCur;
  logic [PTR_W-1:0] afLimit;
  logic push;

  assign push       = wrEn & fullN;
  assign wBinNext   = wBin + PTR_W'(push);
  assign rBinW      = grayToBin(rSyncB);
  assign wCountNext = wBinNext - rBinW;
  assign wCountCur  = wBin - rBinW;
  assign afLimit    = FULL_CNT - {1'b0, fullOfs};

  always_ff @(posedge wrClk or negedge rstN) begin
    if (!rstN) begin
      wBin        <= '0;
      wGray       <= '0;
      rSyncA      <= '0;
      rSyncB      <= '0;
      fullN       <= 1'b1;
      almostFullN <= 1'b1;
    end else begin
      wBin        <= wBinNext;
      wGray       <= wBinNext ^ (wBinNext >> 1);
      rSyncA      <= rGray;
      rSyncB      <= rSyncA;
      fullN       <= (wCountNext != FULL_CNT);
      almostFullN <= (wCountNext < afLimit);
    end
  end

  // read side
  logic [PTR_W-1:0] rBin, rGray, rBinNext, wSyncA, wSyncB, wBinR, rCountNext, rCountCur;
  logic pop;

  assign pop        = rdEn & emptyN;
  assign rBinNext   = rBin + PTR_W'(pop);
  assign wBinR      = grayToBin(wSyncB);
  assign rCountNext = wBinR - rBinNext;
  assign rCountCur  = wBinR - rBin;

  always_ff @(posedge rdClk or negedge rstN) begin
    if (!rstN) begin
      rBin         <= '0;
      rGray        <= '0;
      wSyncA       <= '0;
      wSyncB       <= '0;
      emptyN       <= 1'b0;
      almostEmptyN <= 1'b0;
    end else begin
      rBin         <= rBinNext;
      rGray        <= rBinNext ^ (rBinNext >> 1);
      wSyncA       <= wGray;
      wSyncB       <= wSyncA;
      emptyN       <= (rCountNext != '0);
      almostEmptyN <= (rCountNext > {1'b0, emptyOfs});
    end
  end

  assign strobe.push = push;
  assign strobe.pop  = pop;
  assign wrAddr      = wBin[ADDR_W-1:0];
  assign rdAddr      = rBin[ADDR_W-1:0];

  // write-domain checks
  assert_no_overflow_R3: assert property (@(posedge wrClk) disable iff (!rstN)
    wCountCur <= FULL_CNT) else $error("count above depth");
  assert_full_flag_R2: assert property (@(posedge wrClk) disable iff (!rstN)
    (wCountCur == FULL_CNT) |-> !fullN) else $error("full not flagged");
  assert_almost_full_R5: assert property (@(posedge wrClk) disable iff (!rstN)
    (wCountCur >= afLimit) |-> !almostFullN) else $error("almost-full not flagged");
  assert_wr_gray_step_R9: assert property (@(posedge wrClk) disable iff (!rstN)
    $onehot0(wGray ^ $past(wGray))) else $error("write gray multi-bit step");

  // read-domain checks
  assert_empty_flag_R4: assert property (@(posedge rdClk) disable iff (!rstN)
    (rCountCur == '0) |-> !emptyN) else $error("empty not flagged");
  assert_almost_empty_R6: assert property (@(posedge rdClk) disable iff (!rstN)
    (rCountCur <= {1'b0, emptyOfs}) |-> !almostEmptyN) else $error("almost-empty not flagged");
  assert_rd_gray_step_R9: assert property (@(posedge rdClk) disable iff (!rstN)
    $onehot0(rGray ^ $past(rGray))) else $error("read gray multi-bit step");
endmodule

// File: rtl/fifo_flag_datapath.sv
module fifo_flag_datapath
  import fifo_flag_pkg::*;
#(
  parameter int DEPTH  = 256,
  parameter int ADDR_W = $clog2(DEPTH),
  parameter int DATA_W = 9
) (
  input  logic              wrClk,
  input  logic              rdClk,
  input  logic              rstN,
  input  fifo_strobe_t      strobe,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData
);
  logic [DATA_W-1:0] store [DEPTH];

  always_ff @(posedge wrClk) begin
    if (strobe.push) store[wrAddr] <= wrData;
  end

  always_ff @(posedge rdClk or negedge rstN) begin
    if (!rstN)           rdData <= '0;
    else if (strobe.pop) rdData <= store[rdAddr];
  end

  assert_hold_without_pop_R4: assert property (@(posedge rdClk) disable iff (!rstN)
    !strobe.pop |=> $stable(rdData)) else $error("output moved without a read");
endmodule

// File: rtl/dual_clock_flag_fifo.sv
module dual_clock_flag_fifo
  import fifo_flag_pkg::*;
#(
  parameter int DEPTH   = 256,
  parameter int DATA_W  = 9,
  parameter int RST_OFS = 7,
  parameter int ADDR_W  = $clog2(DEPTH)
) (
  input  logic              wrClk,
  input  logic              rdClk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic              rdEn,
  output logic [DATA_W-1:0] rdData,
  input  logic              cfgLoad,
  input  logic              cfgSel,
  input  logic [ADDR_W-1:0] cfgValue,
  output logic              fullN,
  output logic              almostFullN,
  output logic              almostEmptyN,
  output logic              emptyN
);
  fifo_strobe_t      strobe;
  logic [ADDR_W-1:0] wrAddr, rdAddr;

  fifo_flag_ctrl #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .RST_OFS(RST_OFS)) uCtrl (
    .wrClk(wrClk), .rdClk(rdClk), .rstN(rstN),
    .wrEn(wrEn), .rdEn(rdEn),
    .cfgLoad(cfgLoad), .cfgSel(cfgSel), .cfgValue(cfgValue),
    .strobe(strobe), .wrAddr(wrAddr), .rdAddr(rdAddr),
    .fullN(fullN), .almostFullN(almostFullN),
    .almostEmptyN(almostEmptyN), .emptyN(emptyN)
  );

  fifo_flag_datapath #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) uData (
    .wrClk(wrClk), .rdClk(rdClk), .rstN(rstN),
    .strobe(strobe), .wrAddr(wrAddr), .rdAddr(rdAddr),
    .wrData(wrData), .rdData(rdData)
  );
endmodule

// File: tb/tb_dual_clock_flag_fifo.sv
module tb_dual_clock_flag_fifo;
  localparam int DEPTH  = 256;
  localparam int DATA_W = 9;
  localparam int ADDR_W = 8;

  logic wrClk = 1'b0, rdClk = 1'b0, rstN = 1'b0;
  logic wrEn = 1'b0, rdEn = 1'b0, cfgLoad = 1'b0, cfgSel = 1'b0;
  logic [DATA_W-1:0] wrData = '0;
  logic [ADDR_W-1:0] cfgValue = '0;
  logic [DATA_W-1:0] rdData;
  logic fullN, almostFullN, almostEmptyN, emptyN;

  int checks = 0, failures = 0;
  logic [DATA_W-1:0] modelQ[$];
  int modelM = 7, modelN = 7;
  logic [DATA_W-1:0] nextVal = 9'd5;
  logic [DATA_W-1:0] lastOut = '0;

  always #5   wrClk = ~wrClk;
  always #6.5 rdClk = ~rdClk;

  dual_clock_flag_fifo #(.DEPTH(DEPTH), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) dut (
    .wrClk(wrClk), .rdClk(rdClk), .rstN(rstN),
    .wrEn(wrEn), .wrData(wrData), .rdEn(rdEn), .rdData(rdData),
    .cfgLoad(cfgLoad), .cfgSel(cfgSel), .cfgValue(cfgValue),
    .fullN(fullN), .almostFullN(almostFullN),
    .almostEmptyN(almostEmptyN), .emptyN(emptyN)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h count=%0d", req, act, exp, modelQ.size());
    end
  endtask

  task automatic settle();
    repeat (8) @(negedge wrClk);
    repeat (8) @(negedge rdClk);
  endtask

  // flag check against threshold ranges, after both sides are quiet (R9)
  task automatic checkFlags(input string tag);
    int c;
    c = modelQ.size();
    check({"R2 fullN ", tag},        16'(fullN),        16'(c != DEPTH));
    check({"R5 almostFullN ", tag},  16'(almostFullN),  16'(c < DEPTH - modelM));
    check({"R4 emptyN ", tag},       16'(emptyN),       16'(c != 0));
    check({"R6 almostEmptyN ", tag}, 16'(almostEmptyN), 16'(c > modelN));
  endtask

  task automatic writeOne();
    @(negedge wrClk);
    wrEn = 1'b1;
    wrData = nextVal;
    if (modelQ.size() < DEPTH) modelQ.push_back(nextVal);
    nextVal = nextVal + 9'd37;
    @(negedge wrClk);
    wrEn = 1'b0;
  endtask

  task automatic writeMany(input int k);
    for (int i = 0; i < k; i++) writeOne();
  endtask

  task automatic readOne();
    @(negedge rdClk);
    rdEn = 1'b1;
    @(negedge rdClk);
    rdEn = 1'b0;
    if (modelQ.size() > 0) lastOut = modelQ.pop_front();
    check("R1/R4 rdData order or hold", 16'(rdData), 16'(lastOut));
  endtask

  task automatic readMany(input int k);
    for (int i = 0; i < k; i++) readOne();
  endtask

  task automatic loadOffset(input logic sel, input int val);
    @(negedge wrClk);
    cfgLoad = 1'b1; cfgSel = sel; cfgValue = ADDR_W'(val);
    @(negedge wrClk);
    cfgLoad = 1'b0;
    if (sel) modelM = val; else modelN = val;
  endtask

  task automatic testReset();
    check("R7 emptyN at reset",       16'(emptyN),       16'd0);
    check("R7 almostEmptyN at reset", 16'(almostEmptyN), 16'd0);
    check("R7 almostFullN at reset",  16'(almostFullN),  16'd1);
    check("R7 fullN at reset",        16'(fullN),        16'd1);
    check("R7 rdData at reset",       16'(rdData),       16'd0);
  endtask

  task automatic testDefaultFill();
    writeMany(7);            settle(); checkFlags("R7 default n, count 7");
    writeMany(1);            settle(); checkFlags("count 8");
    writeMany(DEPTH - 16);   settle(); checkFlags("count DEPTH-8");
    writeMany(1);
    check("R5 almostFullN same edge", 16'(almostFullN), 16'd0);
    settle(); checkFlags("count DEPTH-7");
    writeMany(6);            settle(); checkFlags("count DEPTH-1");
    writeMany(1);
    check("R2 fullN same edge", 16'(fullN), 16'd0);
    writeMany(3);            settle(); checkFlags("R3 writes while full");
    readMany(1);             settle(); checkFlags("R9 full released");
    readMany(DEPTH - 2);     settle(); checkFlags("count 1");
    readMany(1);
    check("R4 emptyN same edge", 16'(emptyN), 16'd0);
    settle(); checkFlags("drained");
  endtask

  task automatic testEmptyRead();
    logic [DATA_W-1:0] held;
    held = rdData;
    readMany(2);
    check("R4 rdData held on empty read", 16'(rdData), 16'(held));
    settle(); checkFlags("R4 empty reads");
    writeMany(2); settle();
    readMany(2); settle(); checkFlags("R1 after ignored reads");
  endtask

  task automatic testOffsets();
    loadOffset(1'b1, 3);
    loadOffset(1'b0, 20);
    settle(); checkFlags("R8 new offsets empty");
    writeMany(20);          settle(); checkFlags("R8 R6 count n");
    writeMany(1);           settle(); checkFlags("R6 count n+1");
    writeMany(DEPTH - 25);  settle(); checkFlags("R5 count DEPTH-4");
    writeMany(1);
    check("R5 almostFullN same edge m=3", 16'(almostFullN), 16'd0);
    settle(); checkFlags("R5 count DEPTH-3");
    readMany(1);            settle(); checkFlags("R9 almost-full released");
    readMany(DEPTH - 25);   settle(); checkFlags("R6 count n+1 reading");
    readMany(1);
    check("R6 almostEmptyN same edge n=20", 16'(almostEmptyN), 16'd0);
    readMany(20);           settle(); checkFlags("R1 drained offsets");
  endtask

  initial begin
    #41 rstN = 1'b1;
    settle();
    testReset();
    testDefaultFill();
    testEmptyRead();
    testOffsets();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #2000000;
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule